// File: doc/BRIEF.md
# Debug Instruction Stream Tracker

This block follows the instruction protocol of a two-wire on-chip debug port. It sits behind a frame receiver that supplies one strobe per accepted byte and one strobe per line BREAK. The first byte of every instruction is an opcode. From that opcode the tracker works out how many operand and data items follow, how wide each one is, and which side sends it. It then folds the following bytes into little-endian values and reports each value as it completes.

The tracker also keeps the repeat count that a REPEAT instruction passes on to the instruction after it. Memory accesses are neither executed nor modelled. The outputs are registered strobes: one for the decoded opcode, one for each assembled item, and one that marks the end of the instruction. Downstream logic can build transaction traces or protocol monitors on top of these strobes.

Top module: `dbg_insn_tracker`

## Requirements
- R1: After reset, after an instruction completes, or after a BREAK, the next accepted byte is an opcode. In the cycle after that byte is accepted, `op_valid` pulses, `op_code` holds byte bits 7:5 and `op_arg` holds byte bits 3:0. Bit 4 has no effect. The opcode values are 0 LDS, 1 LD, 2 STS, 3 ST, 4 LDCS, 5 REPEAT, 6 STCS and 7 KEY. All strobes are low while reset is held.
- R2: LDS and STS first expect one address item written by the programmer, of (bits 3:2)+1 bytes. They then expect one data item of (bits 1:0)+1 bytes. For LDS the data item is read (`item_write`=0). For STS it is written (`item_write`=1).
- R3: LD and ST expect count+1 data items of (bits 1:0)+1 bytes each, where count is the pending repeat count. LD items are reads and ST items are writes. Bits 3:2 (pointer mode) do not change the byte count.
- R4: LDCS and STCS move exactly one 1-byte item. LDCS reads it and STCS writes it.
- R5: KEY expects 8 written bytes, reported as two 4-byte write items, low-order item first.
- R6: REPEAT expects one written item of (bits 1:0)+1 bytes. The zero-extended value becomes the repeat count for the next instruction only. Every opcode clears any older count when it is accepted.
- R7: Within an item, the first byte lands in bits 7:0 and each later byte lands in the next higher octet. `item_bytes` reports the item size, 1 to 4.
- R8: `item_valid` pulses in the cycle after the item's last byte is accepted. `insn_done` pulses together with the instruction's final `item_valid`.
- R9: A BREAK aborts the current instruction and clears the repeat count. The next byte is then an opcode. A byte strobed in the same cycle as a BREAK is dropped.
- R10: Within one instruction, every written item is reported before any read item.
- R11: Cycles with `byte_valid` low change nothing and produce no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | Received byte |
| brk_strobe | input | 1 | Line BREAK detected this cycle |
| op_valid | output | 1 | Opcode decoded (one-cycle pulse) |
| op_code | output | 3 | Instruction selector from opcode bits 7:5 |
| op_arg | output | 4 | Opcode bits 3:0 (sizes, pointer mode or register index) |
| item_valid | output | 1 | Assembled item ready (one-cycle pulse) |
| item_value | output | DATA_W | Little-endian assembled item value |
| item_bytes | output | SIZE_W | Item size in bytes |
| item_write | output | 1 | 1: written by programmer, 0: returned by device |
| insn_done | output | 1 | Last item of the instruction reported |

## Verification
The bench targets the repeat handoff in three ways. A REPEAT count must stretch the following LD or ST. The count must vanish when another opcode or a BREAK intervenes. A large count must be cut short cleanly by a BREAK. A tracker that keeps a stale count will then report too many items and miss the opcode that comes next. The bench also covers a BREAK in the middle of an item and a BREAK in the same cycle as a byte, the split of the 8-byte key, and STS and LDS with mixed address and data sizes. In those cases a wrong byte order, a wrong size field or a wrong write-to-read switch point shows up as an item with the wrong value, the wrong width or the wrong direction.

// File: rtl/dit_pkg.sv
package dit_pkg;
  typedef enum logic [2:0] {
    OPC_LDS  = 3'd0,
    OPC_LD   = 3'd1,
    OPC_STS  = 3'd2,
    OPC_ST   = 3'd3,
    OPC_LDCS = 3'd4,
    OPC_REP  = 3'd5,
    OPC_STCS = 3'd6,
    OPC_KEY  = 3'd7
  } opc_e;

  // PH_LEAD: single address item ahead of the body; PH_BODY: data items
  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_LEAD = 2'd1,
    PH_BODY = 2'd2
  } phase_e;
endpackage

// File: rtl/dit_opdecode.sv
module dit_opdecode
  import dit_pkg::*;
#(
  parameter int REP_W     = 32,
  parameter int SIZE_W    = 3,
  parameter int KEY_ITEMS = 2
) (
  input  logic [2:0]        opc_i,
  input  logic [3:0]        arg_i,
  input  logic [REP_W-1:0]  rep_i,
  output logic              lead_en_o,
  output logic [SIZE_W-1:0] lead_size_o,
  output logic [SIZE_W-1:0] body_size_o,
  output logic              body_write_o,
  output logic [REP_W-1:0]  body_extra_o,
  output logic              body_rep_o
);
  logic [SIZE_W-1:0] size_lo;
  logic [SIZE_W-1:0] size_hi;

  assign size_lo = SIZE_W'(arg_i[1:0]) + SIZE_W'(1);
  assign size_hi = SIZE_W'(arg_i[3:2]) + SIZE_W'(1);
  assign lead_size_o = size_hi;

  always_comb begin
    lead_en_o    = 1'b0;
    body_size_o  = size_lo;
    body_write_o = 1'b1;
    body_extra_o = '0;
    body_rep_o   = 1'b0;
    case (opc_e'(opc_i))
      OPC_LDS: begin
        lead_en_o    = 1'b1;
        body_write_o = 1'b0;
      end
      OPC_STS: lead_en_o = 1'b1;
      OPC_LD: begin
        body_write_o = 1'b0;
        body_extra_o = rep_i;
      end
      OPC_ST: body_extra_o = rep_i;
      OPC_LDCS: begin
        body_size_o  = SIZE_W'(1);
        body_write_o = 1'b0;
      end
      OPC_STCS: body_size_o = SIZE_W'(1);
      OPC_REP: body_rep_o = 1'b1;
      OPC_KEY: begin
        body_size_o  = SIZE_W'(4);
        body_extra_o = REP_W'(KEY_ITEMS - 1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dit_assemble.sv
module dit_assemble #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              take_i,
  input  logic              close_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        byte_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int MAX_BYTES = DATA_W / 8;

  logic [DATA_W-1:0] acc;

  assign word_o = acc | (DATA_W'(byte_i) << {idx_i, 3'b000});

  always_ff @(posedge clk) begin
    if (rst || flush_i) acc <= '0;
    else if (take_i)    acc <= close_i ? '0 : word_o;
  end

  // R7: byte index never runs past the item width
  p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
    take_i |-> (int'(idx_i) < MAX_BYTES));
endmodule

// File: rtl/dbg_insn_tracker.sv
module dbg_insn_tracker
  import dit_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REP_W     = 32,
  parameter int KEY_BYTES = 8,
  localparam int MAX_BYTES = DATA_W / 8,
  localparam int SIZE_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              brk_strobe,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic [3:0]        op_arg,
  output logic              item_valid,
  output logic [DATA_W-1:0] item_value,
  output logic [SIZE_W-1:0] item_bytes,
  output logic              item_write,
  output logic              insn_done
);
  localparam int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int KEY_ITEMS = KEY_BYTES / MAX_BYTES;

  phase_e            phase;
  logic [IDX_W-1:0]  byte_idx;
  logic [SIZE_W-1:0] cur_size, body_size_q;
  logic              cur_write, body_write_q, body_rep_q;
  logic [REP_W-1:0]  items_left, rep_cnt;

  logic              d_lead_en, d_body_write, d_body_rep;
  logic [SIZE_W-1:0] d_lead_size, d_body_size;
  logic [REP_W-1:0]  d_body_extra;
  logic [DATA_W-1:0] asm_word;

  logic take_opc, take_dat, item_last;

  assign take_opc  = byte_valid && !brk_strobe && (phase == PH_OPC);
  assign take_dat  = byte_valid && !brk_strobe && (phase != PH_OPC);
  assign item_last = take_dat && ((SIZE_W'(byte_idx) + SIZE_W'(1)) == cur_size);

  dit_opdecode #(
    .REP_W(REP_W), .SIZE_W(SIZE_W), .KEY_ITEMS(KEY_ITEMS)
  ) u_dec (
    .opc_i        (byte_data[7:5]),
    .arg_i        (byte_data[3:0]),
    .rep_i        (rep_cnt),
    .lead_en_o    (d_lead_en),
    .lead_size_o  (d_lead_size),
    .body_size_o  (d_body_size),
    .body_write_o (d_body_write),
    .body_extra_o (d_body_extra),
    .body_rep_o   (d_body_rep)
  );

  dit_assemble #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_asm (
    .clk     (clk),
    .rst     (rst),
    .flush_i (brk_strobe || take_opc),
    .take_i  (take_dat),
    .close_i (item_last),
    .idx_i   (byte_idx),
    .byte_i  (byte_data),
    .word_o  (asm_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_OPC;
      byte_idx     <= '0;
      cur_size     <= '0;
      cur_write    <= 1'b0;
      body_size_q  <= '0;
      body_write_q <= 1'b0;
      body_rep_q   <= 1'b0;
      items_left   <= '0;
      rep_cnt      <= '0;
      op_valid     <= 1'b0;
      op_code      <= '0;
      op_arg       <= '0;
      item_valid   <= 1'b0;
      item_value   <= '0;
      item_bytes   <= '0;
      item_write   <= 1'b0;
      insn_done    <= 1'b0;
    end else begin
      op_valid   <= 1'b0;
      item_valid <= 1'b0;
      insn_done  <= 1'b0;
      if (brk_strobe) begin
        phase    <= PH_OPC;
        rep_cnt  <= '0;
        byte_idx <= '0;
      end else if (take_opc) begin
        op_valid     <= 1'b1;
        op_code      <= byte_data[7:5];
        op_arg       <= byte_data[3:0];
        rep_cnt      <= '0;
        byte_idx     <= '0;
        phase        <= d_lead_en ? PH_LEAD : PH_BODY;
        cur_size     <= d_lead_en ? d_lead_size : d_body_size;
        cur_write    <= d_lead_en ? 1'b1 : d_body_write;
        body_size_q  <= d_body_size;
        body_write_q <= d_body_write;
        body_rep_q   <= d_body_rep;
        items_left   <= d_body_extra;
      end else if (take_dat) begin
        if (!item_last) begin
          byte_idx <= byte_idx + IDX_W'(1);
        end else begin
          byte_idx   <= '0;
          item_valid <= 1'b1;
          item_value <= asm_word;
          item_bytes <= cur_size;
          item_write <= cur_write;
          if (phase == PH_LEAD) begin
            phase     <= PH_BODY;
            cur_size  <= body_size_q;
            cur_write <= body_write_q;
          end else if (items_left == '0) begin
            phase     <= PH_OPC;
            insn_done <= 1'b1;
            if (body_rep_q) rep_cnt <= REP_W'(asm_word);
          end else begin
            items_left <= items_left - REP_W'(1);
          end
        end
      end
    end
  end

  // Tracks whether a read item has already appeared in this instruction
  logic read_seen;
  always_ff @(posedge clk) begin
    if (rst || op_valid)             read_seen <= 1'b0;
    else if (item_valid && !item_write) read_seen <= 1'b1;
  end

  p_write_first_r10: assert property (@(posedge clk) disable iff (rst)
    (item_valid && item_write) |-> !read_seen);

  p_done_with_item_r8: assert property (@(posedge clk) disable iff (rst)
    insn_done |-> item_valid);

  p_opc_item_apart_r1: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && item_valid));

  p_break_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    brk_strobe |=> !(op_valid || item_valid || insn_done));

  p_break_clears_rep_r9: assert property (@(posedge clk) disable iff (rst)
    brk_strobe |=> (rep_cnt == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> !(op_valid || item_valid || insn_done));

  p_size_range_r7: assert property (@(posedge clk) disable iff (rst)
    item_valid |-> (item_bytes != '0 && int'(item_bytes) <= MAX_BYTES));
endmodule

// File: tb/dbg_insn_tracker_tb_top.sv
module dbg_insn_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        brk_strobe = 1'b0;
  logic        op_valid, item_valid, item_write, insn_done;
  logic [2:0]  op_code;
  logic [3:0]  op_arg;
  logic [31:0] item_value;
  logic [2:0]  item_bytes;

  always #2 clk = ~clk;

  dbg_insn_tracker dut_i (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .brk_strobe(brk_strobe), .op_valid(op_valid), .op_code(op_code),
    .op_arg(op_arg), .item_valid(item_valid), .item_value(item_value),
    .item_bytes(item_bytes), .item_write(item_write), .insn_done(insn_done)
  );

  int checks = 0;
  int errors = 0;

  // expected outputs for the cycle after the current input
  bit     e_op, e_item, e_done, e_wr;
  int     e_code, e_arg, e_bytes;
  longint e_val;
  string  e_tag = "R1 reset";

  // behavioural model state
  bit     m_busy = 0;
  bit     m_isrep = 0;
  int     q_size[$];
  bit     q_wr[$];
  int     m_idx = 0;
  longint m_acc = 0;
  longint m_rep = 0;

  task automatic compare();
    bit bad;
    bad = (op_valid !== e_op) || (item_valid !== e_item) || (insn_done !== e_done);
    if (e_op && (op_code !== 3'(e_code) || op_arg !== 4'(e_arg))) bad = 1;
    if (e_item && (item_value !== 32'(e_val) || item_bytes !== 3'(e_bytes) ||
                   item_write !== e_wr)) bad = 1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: actual op=%0b code=%0d arg=%0d item=%0b val=%h bytes=%0d wr=%0b done=%0b expected op=%0b code=%0d arg=%0d item=%0b val=%h bytes=%0d wr=%0b done=%0b",
               e_tag, op_valid, op_code, op_arg, item_valid, item_value, item_bytes,
               item_write, insn_done, e_op, e_code, e_arg, e_item, 32'(e_val),
               e_bytes, e_wr, e_done);
    end
  endtask

  task automatic push(int sz, bit wr);
    q_size.push_back(sz);
    q_wr.push_back(wr);
  endtask

  task automatic model(bit v, int d, bit b);
    int op, dz, az;
    longint n;
    e_op = 0; e_item = 0; e_done = 0;
    if (b) begin
      m_busy = 0; q_size.delete(); q_wr.delete(); m_idx = 0; m_acc = 0; m_rep = 0;
    end else if (v) begin
      if (!m_busy) begin
        op = d >> 5; dz = (d & 3) + 1; az = ((d >> 2) & 3) + 1;
        e_op = 1; e_code = op; e_arg = d & 15;
        n = m_rep + 1; m_rep = 0; m_isrep = (op == 5);
        m_busy = 1; m_idx = 0; m_acc = 0;
        case (op)
          0: begin push(az, 1); push(dz, 0); end
          1: for (longint k = 0; k < n; k++) push(dz, 0);
          2: begin push(az, 1); push(dz, 1); end
          3: for (longint k = 0; k < n; k++) push(dz, 1);
          4: push(1, 0);
          5: push(dz, 1);
          6: push(1, 1);
          default: begin push(4, 1); push(4, 1); end
        endcase
      end else begin
        m_acc = m_acc | (longint'(d) << (8 * m_idx));
        m_idx++;
        if (m_idx == q_size[0]) begin
          e_item = 1; e_val = m_acc; e_bytes = m_idx; e_wr = q_wr[0];
          void'(q_size.pop_front()); void'(q_wr.pop_front());
          m_idx = 0; m_acc = 0;
          if (q_size.size() == 0) begin
            e_done = 1; m_busy = 0;
            if (m_isrep) m_rep = e_val;
          end
        end
      end
    end
  endtask

  task automatic step(bit v, int d, bit b, string tag);
    @(negedge clk);
    compare();
    byte_valid = v; byte_data = 8'(d); brk_strobe = b;
    model(v, d, b);
    e_tag = tag;
  endtask

  task automatic send(int d, string tag);
    step(1, d, 0, tag);
  endtask

  task automatic idle(string tag);
    step(0, 8'hFF, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    e_op = 0; e_item = 0; e_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R1 reset");
    // R2 LDS a2 m3, with idle gaps (R11)
    send(8'h06, "R1 LDS opcode");
    send(8'h34, "R2 LDS addr");
    idle("R11 gap");
    send(8'h12, "R2 LDS addr");
    send(8'hAA, "R2 LDS data");
    idle("R11 gap");
    send(8'hBB, "R2 LDS data");
    send(8'hCC, "R2 LDS read item");
    // R2/R7 STS a1 i4
    send(8'h43, "R1 STS opcode");
    send(8'h10, "R2 STS addr");
    send(8'h01, "R7 STS data");
    send(8'h02, "R7 STS data");
    send(8'h03, "R7 STS data");
    send(8'h04, "R7 STS little-endian");
    // R4 LDCS / STCS
    send(8'h82, "R4 LDCS opcode");
    send(8'h5A, "R4 LDCS read");
    send(8'hC1, "R4 STCS opcode");
    send(8'h01, "R4 STCS write");
    // R5 KEY
    send(8'hE0, "R5 KEY opcode");
    for (int i = 1; i <= 8; i++) send(i * 8'h11, "R5 KEY bytes");
    // R6/R3 REPEAT 2 then LD m1
    send(8'hA0, "R6 REPEAT opcode");
    send(8'h02, "R6 REPEAT count");
    send(8'h24, "R3 LD opcode");
    send(8'h71, "R3 LD item");
    send(8'h72, "R3 LD item");
    send(8'h73, "R3 LD last item");
    send(8'h20, "R6 count consumed");
    send(8'h99, "R6 single item");
    // R6 4-byte count, ST m2 with bit4 set (R1)
    send(8'hA3, "R6 REPEAT i4");
    send(8'h01, "R6 count"); send(8'h00, "R6 count");
    send(8'h00, "R6 count"); send(8'h00, "R6 count");
    send(8'h7D, "R1 bit4 ignored ST");
    send(8'hEF, "R3 ST item"); send(8'hBE, "R3 ST item");
    send(8'hAD, "R3 ST item"); send(8'hDE, "R3 ST last");
    // R6 intervening opcode clears count
    send(8'hA0, "R6 REPEAT"); send(8'h03, "R6 count");
    send(8'h80, "R6 LDCS"); send(8'h00, "R6 LDCS read");
    send(8'h20, "R6 LD after LDCS"); send(8'h55, "R6 count cleared");
    // R9 BREAK clears count
    send(8'hA0, "R9 REPEAT"); send(8'h03, "R9 count");
    step(0, 0, 1, "R9 break");
    send(8'h20, "R9 LD after break"); send(8'h66, "R9 count cleared");
    // R9 BREAK mid item
    send(8'h43, "R9 STS"); send(8'h10, "R9 addr"); send(8'h01, "R9 partial");
    step(0, 0, 1, "R9 break mid item");
    send(8'h82, "R9 new opcode"); send(8'h77, "R9 LDCS read");
    // R9 byte with BREAK in same cycle dropped
    step(1, 8'h43, 1, "R9 byte dropped");
    send(8'h80, "R9 opcode after drop"); send(8'h12, "R9 LDCS read");
    // R3 long repeat cut by BREAK
    send(8'hA1, "R3 REPEAT i2"); send(8'h00, "R3 count"); send(8'h01, "R3 count");
    send(8'h20, "R3 LD x257");
    for (int i = 0; i < 5; i++) send(8'h30 + i, "R3 LD repeated item");
    step(0, 0, 1, "R9 break long LD");
    send(8'hC2, "R9 STCS after break"); send(8'h44, "R9 STCS write");
    idle("R11 idle");
    idle("R11 idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule